// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Nesting Unit

This block is the per-processor front end that sits between an interrupt arbiter and the processor's register port. On an acknowledge request it takes the arbiter's highest-pending interrupt number. If that interrupt is more urgent than the one already being serviced, the unit grants it. A grant asks for the pending flag to be cleared, records the preempted interrupt as the new one's predecessor, and raises the running priority. Otherwise the unit answers with the spurious number 1023 and changes nothing.

On an end-of-interrupt request the unit retires the named interrupt. If the interrupt is level-sensitive and its line is still asserted, the unit asks for it to be made pending again. When the named interrupt is the one running, its predecessor takes over. When it is one further down the nesting chain, a small walker follows the predecessor links one per cycle and splices that entry out of the chain. The predecessor links live in a synchronous table indexed by interrupt number.

Both request channels use valid/ready. A request transfers on a clock edge where valid and ready are both high. The requester holds valid and its data stable until then. Neither channel is ready while the walker is busy. When both requests arrive in the same idle cycle, the acknowledge is taken and the completion waits. The acknowledge response, pending-clear and pending-set outputs are single-cycle valid pulses with no back-pressure, so the consumer must take them in the cycle they appear. The unit needs `NUM_IRQ` to be a power of two no larger than 512, which keeps 1023 outside the implemented range. Priority value 0 is the most urgent. With `PRIO_W` = 8, the idle running priority is 0x100.

Top module: `irq_nest_unit`

## Requirements
- R1: An accepted acknowledge whose candidate is 1023, is out of range, or has a priority value greater than or equal to the running priority produces a response of 1023 one cycle later, and the running ID and running priority do not change.
- R2: An accepted acknowledge of a more urgent candidate produces a response carrying that ID one cycle later. In the same cycle the candidate becomes the running ID, its priority becomes the running priority, and the previous running ID is stored as its predecessor.
- R3: A granted acknowledge emits a one-cycle pending-clear pulse for the granted ID. Its all-processors flag is 1 when the interrupt's one-of-N model bit is set, and 0 when only this processor's flag is to be cleared.
- R4: Whenever the running ID is 1023, including after reset, the running priority is 2^PRIO_W (0x100 by default).
- R5: A completion uses only bits [9:0] of the written word. It is ignored, with no state change and no pending-set pulse, when that ID is not below NUM_IRQ or when the running ID is 1023.
- R6: A completion that is taken emits a pending-set pulse for that ID one cycle after acceptance exactly when the interrupt is level-sensitive (its edge bit is 0), enabled, has its line high, and targets this processor.
- R7: Completing the running ID makes its predecessor the running ID two cycles after acceptance, and the running priority follows: it takes the predecessor's priority, or 0x100 when the predecessor is 1023.
- R8: Completing an ID that is not running leaves the running ID unchanged. The walker, with busy high, follows one predecessor link per cycle from the running ID. The entry that points at the completed ID is relinked to that ID's own predecessor.
- R9: Both request channels have ready low while busy. In an idle cycle where an acknowledge is offered, the completion channel is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_id | input | 10 | Highest-pending ID from the arbiter |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt, ID i at bits [i*PRIO_W +: PRIO_W] |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irq_one_of_n | input | NUM_IRQ | 1 = one-of-N model (clear for all processors) |
| irq_en | input | NUM_IRQ | Interrupt enable for this processor |
| irq_line | input | NUM_IRQ | Current input line level |
| irq_tgt | input | NUM_IRQ | Interrupt targets this processor |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge request ready |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_id | output | 10 | Acknowledged ID or 1023 |
| eoi_valid | input | 1 | Completion request valid |
| eoi_ready | output | 1 | Completion request ready |
| eoi_data | input | 32 | Completion word; bits [9:0] are the ID |
| pend_clr_valid | output | 1 | Pending-clear pulse |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all processors |
| pend_set_valid | output | 1 | Pending-set pulse for this processor |
| pend_set_id | output | 10 | ID to set pending |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority |
| busy | output | 1 | Chain walk or pop in progress |

## Verification
An acknowledge and a completion can be offered in the same idle cycle. The bench provokes this by raising both valids on one edge while one interrupt is running. It expects the completion channel to show not-ready. The acknowledge is taken and preempts, and the held completion is accepted on a later edge. Because the completed ID is no longer running, the held completion must take the chain-unlink path. A final completion of the new running ID must then return the unit to idle, which shows that the splice was correct.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int ID_W = 10;
  typedef logic [ID_W-1:0] irq_id_t;
  localparam irq_id_t NO_IRQ = 10'd1023;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POP  = 2'd1,
    ST_WALK = 2'd2,
    ST_LINK = 2'd3
  } nest_state_e;
endpackage

// File: rtl/irq_attr_sel.sv
module irq_attr_sel
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  irq_id_t                   id,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_vec,
  input  logic [NUM_IRQ-1:0]        edge_vec,
  input  logic [NUM_IRQ-1:0]        model_vec,
  input  logic [NUM_IRQ-1:0]        en_vec,
  input  logic [NUM_IRQ-1:0]        line_vec,
  input  logic [NUM_IRQ-1:0]        tgt_vec,
  output logic                      in_range,
  output logic [PRIO_W-1:0]         prio,
  output logic                      one_of_n,
  output logic                      can_reassert
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  logic [IDX_W-1:0] idx;

  always_comb begin
    in_range     = (32'(id) < NUM_IRQ);
    idx          = id[IDX_W-1:0];
    prio         = '1;
    one_of_n     = 1'b0;
    can_reassert = 1'b0;
    if (in_range) begin
      prio         = prio_vec[idx*PRIO_W +: PRIO_W];
      one_of_n     = model_vec[idx];
      can_reassert = !edge_vec[idx] && en_vec[idx] && line_vec[idx] && tgt_vec[idx];
    end
  end
endmodule

// File: rtl/irq_pred_ram.sv
module irq_pred_ram
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  irq_id_t       wdata,
  input  logic [AW-1:0] raddr,
  output irq_id_t       rdata
);
  irq_id_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= NO_IRQ;
      rdata <= NO_IRQ;
    end else begin
      rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/irq_nest_unit.sv
module irq_nest_unit
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ    = 64,
  parameter int PRIO_W     = 8,
  parameter int WALK_LIMIT = NUM_IRQ
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ID_W-1:0]           hp_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [NUM_IRQ-1:0]        irq_edge,
  input  logic [NUM_IRQ-1:0]        irq_one_of_n,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ-1:0]        irq_line,
  input  logic [NUM_IRQ-1:0]        irq_tgt,
  input  logic                      ack_valid,
  output logic                      ack_ready,
  output logic                      ack_rsp_valid,
  output logic [ID_W-1:0]           ack_rsp_id,
  input  logic                      eoi_valid,
  output logic                      eoi_ready,
  input  logic [31:0]               eoi_data,
  output logic                      pend_clr_valid,
  output logic [ID_W-1:0]           pend_clr_id,
  output logic                      pend_clr_all,
  output logic                      pend_set_valid,
  output logic [ID_W-1:0]           pend_set_id,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      busy
);
  localparam int AW     = $clog2(NUM_IRQ);
  localparam int STEP_W = $clog2(WALK_LIMIT + 1);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  nest_state_e state;
  irq_id_t     walk_cur, walk_goal;
  logic [STEP_W-1:0] steps;

  // attribute lookups for the three IDs of interest
  logic hp_in, hp_model, hp_unused;
  logic [PRIO_W-1:0] hp_prio;
  logic eo_in, eo_model, eo_reassert;
  logic [PRIO_W-1:0] eo_prio;
  logic rd_in, rd_model, rd_unused;
  logic [PRIO_W-1:0] rd_prio;

  irq_id_t eoi_id, rd_id;
  assign eoi_id = eoi_data[ID_W-1:0];

  irq_attr_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_hp_attr (
    .id(hp_id), .prio_vec(irq_prio), .edge_vec(irq_edge), .model_vec(irq_one_of_n),
    .en_vec(irq_en), .line_vec(irq_line), .tgt_vec(irq_tgt),
    .in_range(hp_in), .prio(hp_prio), .one_of_n(hp_model), .can_reassert(hp_unused));

  irq_attr_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_eoi_attr (
    .id(eoi_id), .prio_vec(irq_prio), .edge_vec(irq_edge), .model_vec(irq_one_of_n),
    .en_vec(irq_en), .line_vec(irq_line), .tgt_vec(irq_tgt),
    .in_range(eo_in), .prio(eo_prio), .one_of_n(eo_model), .can_reassert(eo_reassert));

  irq_attr_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_rd_attr (
    .id(rd_id), .prio_vec(irq_prio), .edge_vec(irq_edge), .model_vec(irq_one_of_n),
    .en_vec(irq_en), .line_vec(irq_line), .tgt_vec(irq_tgt),
    .in_range(rd_in), .prio(rd_prio), .one_of_n(rd_model), .can_reassert(rd_unused));

  // handshakes: acknowledge has precedence over completion
  logic ack_fire, eoi_fire, grant, eoi_take;
  assign ack_ready = (state == ST_IDLE);
  assign eoi_ready = (state == ST_IDLE) && !ack_valid;
  assign busy      = (state != ST_IDLE);
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;
  assign grant     = ack_fire && hp_in && ({1'b0, hp_prio} < run_prio);
  assign eoi_take  = eoi_fire && eo_in && (run_id != NO_IRQ);

  // predecessor table port control
  logic    ram_we;
  irq_id_t ram_waddr_id, ram_wdata, ram_raddr_id;

  always_comb begin
    ram_we       = grant || (state == ST_LINK);
    ram_waddr_id = grant ? irq_id_t'(hp_id) : walk_cur;
    ram_wdata    = grant ? irq_id_t'(run_id) : rd_id;
    if (state == ST_WALK) ram_raddr_id = (rd_id == walk_goal) ? walk_goal : rd_id;
    else                  ram_raddr_id = run_id;
  end

  irq_pred_ram #(.DEPTH(NUM_IRQ)) u_pred (
    .clk(clk), .rst_n(rst_n), .we(ram_we),
    .waddr(ram_waddr_id[AW-1:0]), .wdata(ram_wdata),
    .raddr(ram_raddr_id[AW-1:0]), .rdata(rd_id));

  logic [PRIO_W:0] pop_prio;
  assign pop_prio = (rd_id == NO_IRQ || !rd_in) ? IDLE_PRIO : {1'b0, rd_prio};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      run_id         <= NO_IRQ;
      run_prio       <= IDLE_PRIO;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= NO_IRQ;
      pend_clr_valid <= 1'b0;
      pend_clr_id    <= NO_IRQ;
      pend_clr_all   <= 1'b0;
      pend_set_valid <= 1'b0;
      pend_set_id    <= NO_IRQ;
      walk_cur       <= NO_IRQ;
      walk_goal      <= NO_IRQ;
      steps          <= '0;
    end else begin
      ack_rsp_valid  <= 1'b0;
      pend_clr_valid <= 1'b0;
      pend_set_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ack_fire) begin
            ack_rsp_valid <= 1'b1;
            ack_rsp_id    <= grant ? hp_id : NO_IRQ;
            if (grant) begin
              run_id         <= hp_id;
              run_prio       <= {1'b0, hp_prio};
              pend_clr_valid <= 1'b1;
              pend_clr_id    <= hp_id;
              pend_clr_all   <= hp_model;
            end
          end else if (eoi_take) begin
            pend_set_valid <= eo_reassert;
            pend_set_id    <= eoi_id;
            walk_goal      <= eoi_id;
            walk_cur       <= run_id;
            steps          <= '0;
            state          <= (eoi_id == run_id) ? ST_POP : ST_WALK;
          end
        end
        ST_POP: begin
          run_id   <= rd_id;
          run_prio <= pop_prio;
          state    <= ST_IDLE;
        end
        ST_WALK: begin
          if (rd_id == NO_IRQ || steps == STEP_W'(WALK_LIMIT - 1)) begin
            state <= ST_IDLE;
          end else if (rd_id == walk_goal) begin
            state <= ST_LINK;
          end else begin
            walk_cur <= rd_id;
            steps    <= steps + 1'b1;
          end
        end
        ST_LINK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_nest_unit_chk.sv
module irq_nest_unit_chk
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic              ack_rsp_valid,
  input logic [ID_W-1:0]   ack_rsp_id,
  input logic              eoi_valid,
  input logic              eoi_ready,
  input logic [31:0]       eoi_data,
  input logic              pend_clr_valid,
  input logic [ID_W-1:0]   pend_clr_id,
  input logic              pend_set_valid,
  input logic [ID_W-1:0]   run_id,
  input logic [PRIO_W:0]   run_prio,
  input logic              busy
);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id == NO_IRQ) |-> (run_id == $past(run_id) && run_prio == $past(run_prio))); // R1
  AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id != NO_IRQ) |-> (run_id == ack_rsp_id && run_prio < $past(run_prio))); // R2
  AST_CLR_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_valid |-> (ack_rsp_valid && pend_clr_id == ack_rsp_id)); // R3
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO)); // R4
  AST_EOI_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && 32'(eoi_data[ID_W-1:0]) >= NUM_IRQ) |=> (!busy && !pend_set_valid && $stable(run_id))); // R5
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ack_ready && !eoi_ready)); // R9
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |-> !eoi_ready); // R9
endmodule

bind irq_nest_unit irq_nest_unit_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
  .ack_rsp_valid(ack_rsp_valid), .ack_rsp_id(ack_rsp_id), .eoi_valid(eoi_valid),
  .eoi_ready(eoi_ready), .eoi_data(eoi_data), .pend_clr_valid(pend_clr_valid),
  .pend_clr_id(pend_clr_id), .pend_set_valid(pend_set_valid), .run_id(run_id),
  .run_prio(run_prio), .busy(busy));

// File: tb/irq_nest_unit_tb.sv
module irq_nest_unit_tb_top;
  localparam int NI = 64;
  localparam int PW = 8;

  typedef struct packed {
    logic        is_ack;
    logic [31:0] data;
    logic [9:0]  exp_rsp;
    logic [9:0]  exp_run;
    logic [8:0]  exp_prio;
    logic [1:0]  exp_clr;   // 0 none, 1 this cpu, 2 all
    logic        exp_set;
  } vec_t;

  // priority of ID i is 0xC0 - 2*i: 3->BA 5->B6 10->AC 11->AA 20->98
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd5,          10'd5,    10'd5,    9'h0B6, 2'd1, 1'b0}, // R2 R3
    '{1'b1, 32'd3,          10'd1023, 10'd5,    9'h0B6, 2'd0, 1'b0}, // R1 equal-or-lower urgency
    '{1'b1, 32'd10,         10'd10,   10'd10,   9'h0AC, 2'd1, 1'b0}, // R2
    '{1'b1, 32'd20,         10'd20,   10'd20,   9'h098, 2'd2, 1'b0}, // R3 one-of-N
    '{1'b1, 32'd1023,       10'd1023, 10'd20,   9'h098, 2'd0, 1'b0}, // R1 spurious
    '{1'b0, 32'd10,         10'd0,    10'd20,   9'h098, 2'd0, 1'b1}, // R8 R6 unlink mid-chain
    '{1'b0, 32'd20,         10'd0,    10'd5,    9'h0B6, 2'd0, 1'b0}, // R7
    '{1'b0, 32'd5,          10'd0,    10'd1023, 9'h100, 2'd0, 1'b0}, // R7 R4
    '{1'b0, 32'd5,          10'd0,    10'd1023, 9'h100, 2'd0, 1'b0}, // R5 nothing running
    '{1'b1, 32'd11,         10'd11,   10'd11,   9'h0AA, 2'd1, 1'b0}, // R2
    '{1'b0, 32'd100,        10'd0,    10'd11,   9'h0AA, 2'd0, 1'b0}, // R5 out of range
    '{1'b0, 32'hFFFF_FC0B,  10'd0,    10'd1023, 9'h100, 2'd0, 1'b0}, // R5 R6 line low
    '{1'b1, 32'd20,         10'd20,   10'd20,   9'h098, 2'd2, 1'b0}, // R3
    '{1'b0, 32'h0000_0414,  10'd0,    10'd1023, 9'h100, 2'd0, 1'b0}  // R5 upper bits ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [9:0] hp_id = 10'd1023;
  logic [NI*PW-1:0] irq_prio;
  logic [NI-1:0] irq_edge, irq_one_of_n, irq_en, irq_line, irq_tgt;
  logic ack_valid = 1'b0, eoi_valid = 1'b0;
  logic [31:0] eoi_data = '0;
  logic ack_ready, ack_rsp_valid, eoi_ready, pend_clr_valid, pend_clr_all;
  logic pend_set_valid, busy;
  logic [9:0] ack_rsp_id, pend_clr_id, pend_set_id, run_id;
  logic [PW:0] run_prio;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [9:0] got_rsp;
  logic [1:0] got_clr;
  logic got_set, got_busy;

  irq_nest_unit #(.NUM_IRQ(NI), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .irq_prio(irq_prio), .irq_edge(irq_edge),
    .irq_one_of_n(irq_one_of_n), .irq_en(irq_en), .irq_line(irq_line), .irq_tgt(irq_tgt),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_data(eoi_data), .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id),
    .pend_clr_all(pend_clr_all), .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id),
    .run_id(run_id), .run_prio(run_prio), .busy(busy));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_ack(input logic [9:0] id);
    @(negedge clk);
    hp_id = id; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    got_rsp = ack_rsp_valid ? ack_rsp_id : 10'h3FE;
    got_clr = !pend_clr_valid ? 2'd0 : (pend_clr_all ? 2'd2 : 2'd1);
    if (pend_clr_valid && pend_clr_id != ack_rsp_id) got_clr = 2'd3;
  endtask

  task automatic do_eoi(input logic [31:0] w);
    @(negedge clk);
    eoi_data = w; eoi_valid = 1'b1;
    for (int k = 0; k < 200 && !eoi_ready; k++) @(negedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    got_set = pend_set_valid && (pend_set_id == w[9:0]);
    got_busy = busy;
    for (int k = 0; k < 200 && busy; k++) begin
      @(negedge clk);
      if (pend_set_valid) got_set = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < NI; i++) irq_prio[i*PW +: PW] = 8'(8'hC0 - 2*i);
    irq_edge = '1; irq_edge[10] = 1'b0; irq_edge[11] = 1'b0;
    irq_one_of_n = '0; irq_one_of_n[20] = 1'b1;
    irq_en = '1; irq_tgt = '1;
    irq_line = '0; irq_line[10] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R4 reset run_id", run_id, 1023);
    check("R4 reset run_prio", run_prio, 'h100);
    check("R9 reset ready", {ack_ready, eoi_ready, busy}, 3'b110);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].is_ack) begin
        do_ack(VECS[v].data[9:0]);
        check($sformatf("R1/R2 v%0d rsp", v), got_rsp, VECS[v].exp_rsp);
        check($sformatf("R3 v%0d clr", v), got_clr, VECS[v].exp_clr);
      end else begin
        do_eoi(VECS[v].data);
        check($sformatf("R6 v%0d set", v), got_set, VECS[v].exp_set);
        if (v == 5) check("R8 walk busy", got_busy, 1);
      end
      check($sformatf("R7/R8 v%0d run_id", v), run_id, VECS[v].exp_run);
      check($sformatf("R4 v%0d run_prio", v), run_prio, VECS[v].exp_prio);
    end

    // simultaneous acknowledge and completion
    do_ack(10'd5);
    @(negedge clk);
    hp_id = 10'd10; ack_valid = 1'b1; eoi_data = 32'd5; eoi_valid = 1'b1;
    #1 check("R9 eoi held off by ack", eoi_ready, 0);
    @(negedge clk);
    ack_valid = 1'b0;
    check("R2 simultaneous ack rsp", ack_rsp_valid ? ack_rsp_id : 10'h3FE, 10);
    for (int k = 0; k < 20 && !eoi_ready; k++) @(negedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    check("R8 held eoi keeps running", run_id, 10);
    check("R8 held eoi keeps prio", run_prio, 'hAC);
    do_eoi(32'd10);
    check("R8 spliced chain ends idle", run_id, 1023);
    check("R4 idle prio after splice", run_prio, 'h100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule